// File: doc/BRIEF.md
# Serial EEPROM Boot Read Engine

This block fetches configuration words from a three-wire serial EEPROM at power-up. When reset ends it looks at the level of the EEPROM's data line. A high level means a device is fitted. A low level means no device is present, and the engine then stays idle for good. When a device is present, the engine first reads word 0 on its own. It then serves single-word read requests from a configuration loader through a request, address and word-valid handshake.

The two sizes of device take different word-address widths, either 6 or 8 bits. The engine finds out which one is fitted during the first read. It keeps chip select high and sends zero address bits. On the tenth rising edge of the serial clock it samples the data line. The small device is already driving its leading zero at that edge, while the larger device still leaves the line pulled high. The width found there is used for every later read.

Each frame sends a start bit, a two-bit read opcode and the address MSB first. The device returns one zero bit and then 16 data bits MSB first. The serial clock is the system clock divided by twice `HALF_DIV`, which gives 1 MHz from 200 MHz at the default setting.

Top module: `mw_eeprom_reader`

## Requirements
- R1: The engine samples the data-in line when reset is released. If the line is low, `no_eeprom` goes to 1 and stays there, `busy` is 0, all requests are ignored and chip select never asserts.
- R2: If the line is high when reset is released, the engine reads word address 0 without any request. It holds `busy` high until that word has been delivered with `word_valid`.
- R3: A read frame sends, on the data-out line, a start bit 1, then the opcode bits 1 and 0, then the word address MSB first. The address is 6 or 8 bits wide.
- R4: The serial clock idles low. Inside a frame it stays high for exactly `HALF_DIV` system cycles and low for exactly `HALF_DIV` system cycles.
- R5: The data-out line changes only while the serial clock is low, so it is stable across each rising edge and throughout each high phase.
- R6: During the first read, a low level on data-in at the tenth rising serial-clock edge selects 6-bit addressing (`wide_addr` = 0). A high level selects 8-bit addressing (`wide_addr` = 1). The chosen width applies to all later reads.
- R7: In 6-bit mode the two upper bits of `rd_addr` are ignored.
- R8: After the address, one dummy bit time passes. The next 16 rising edges then capture the data MSB first. `word_valid` is a one-cycle pulse that comes with the complete word on `word_data`.
- R9: Chip select stays low for at least 2×`HALF_DIV` system cycles between frames. The serial clock is low whenever chip select is low.
- R10: A request is taken only while `busy` is 0. A request raised while `busy` is 1 causes no read and no `word_valid`.
- R11: `busy` rises in the cycle after a request is accepted. It stays high through the frame and through the chip-select gap that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ee_di | input | 1 | Serial data from the EEPROM; its level at reset release marks presence |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_do | output | 1 | Serial command/address data to the EEPROM |
| rd_req | input | 1 | Read request, sampled while `busy` is 0 |
| rd_addr | input | AW_LARGE | Word address of the request |
| busy | output | 1 | Engine is running a frame, its chip-select gap, or the start-up decision |
| word_valid | output | 1 | One-cycle pulse: `word_data` holds a finished word |
| word_data | output | DATA_W | Last word read |
| no_eeprom | output | 1 | No device was seen at reset release |
| wide_addr | output | 1 | 8-bit addressing was detected |

## Verification
On the small device, the width probe falls on the same serial-clock edge as the dummy bit that comes before the data. That one edge must switch the address width and also move the start of the data-capture window. A device model that answers with the width chosen by the bench provokes this. Separate resets run it once as the small part and once as the large part. The result is judged by comparing every delivered word, including the automatic word 0, against a scoreboard built from the masked address, and by reading `wide_addr` after the start-up read.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_ABSENT
  } mw_state_e;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int HALF_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/mw_cmd_bit.sv
module mw_cmd_bit #(
  parameter int AW_SMALL = 6,
  parameter int AW_LARGE = 8,
  parameter int K_W      = 5
) (
  input  logic [K_W-1:0]      idx,
  input  logic                wide,
  input  logic [AW_LARGE-1:0] addr,
  output logic                bit_o
);
  localparam int AI_W = $clog2(AW_LARGE);

  int            i_int;
  int            aw_int;
  int            pos_int;
  logic [AI_W-1:0] psel;

  // idx 0: start, idx 1..2: opcode 1,0, then address MSB first
  always_comb begin
    i_int   = int'(idx);
    aw_int  = wide ? AW_LARGE : AW_SMALL;
    pos_int = aw_int - 1 - (i_int - 3);
    psel    = AI_W'(pos_int);
    if (i_int < 2)               bit_o = 1'b1;
    else if (i_int == 2)         bit_o = 1'b0;
    else if (i_int < 3 + aw_int) bit_o = addr[psel];
    else                         bit_o = 1'b0;
  end
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    if (clr)           data_n = '0;
    else if (shift_en) data_n = {data_q[DATA_W-2:0], din};
    else               data_n = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_n;
  end

  assign data = data_q;
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int HALF_DIV = 100,
  parameter int AW_SMALL = 6,
  parameter int AW_LARGE = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ee_di,
  output logic                ee_cs,
  output logic                ee_sk,
  output logic                ee_do,
  input  logic                rd_req,
  input  logic [AW_LARGE-1:0] rd_addr,
  output logic                busy,
  output logic                word_valid,
  output logic [DATA_W-1:0]   word_data,
  output logic                no_eeprom,
  output logic                wide_addr
);
  localparam int K_W     = $clog2(AW_LARGE + DATA_W + 5);
  localparam int PROBE_K = AW_SMALL + 4;

  // reset release synchroniser
  logic rs_q1, rs_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i = rs_q2;

  // data-in synchroniser, filled during the reset release delay
  logic di_q1, di_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      di_q1 <= 1'b0;
      di_s  <= 1'b0;
    end else begin
      di_q1 <= ee_di;
      di_s  <= di_q1;
    end
  end

  mw_state_e             state_q, state_n;
  logic [K_W-1:0]        k_q, k_n;
  logic                  wide_q, wide_n;
  logic                  first_q, first_n;
  logic [AW_LARGE-1:0]   addr_q, addr_n;
  logic                  cs_q, cs_n, sk_q, sk_n, do_q, do_n;
  logic                  wv_q, wv_n, noe_q, noe_n, gap_q, gap_n;
  logic                  launch, rx_clr, rx_shift, tick, run, nxt_bit;
  int                    kin, aw_now, aw_probe;

  assign run = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_GAP);

  mw_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i), .run(run), .tick(tick)
  );

  mw_cmd_bit #(.AW_SMALL(AW_SMALL), .AW_LARGE(AW_LARGE), .K_W(K_W)) u_cmd (
    .idx(k_q), .wide(wide_q), .addr(addr_q), .bit_o(nxt_bit)
  );

  mw_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_i), .clr(rx_clr), .shift_en(rx_shift),
    .din(di_s), .data(word_data)
  );

  always_comb begin
    state_n  = state_q;
    k_n      = k_q;
    wide_n   = wide_q;
    first_n  = first_q;
    addr_n   = addr_q;
    cs_n     = cs_q;
    sk_n     = sk_q;
    do_n     = do_q;
    wv_n     = 1'b0;
    noe_n    = noe_q;
    gap_n    = gap_q;
    launch   = 1'b0;
    rx_clr   = 1'b0;
    rx_shift = 1'b0;
    kin      = int'(k_q) + 1;
    aw_now   = wide_q ? AW_LARGE : AW_SMALL;
    aw_probe = aw_now;

    case (state_q)
      ST_WAKE: begin
        if (di_s) begin
          first_n = 1'b1;
          wide_n  = 1'b1;
          addr_n  = '0;
          launch  = 1'b1;
        end else begin
          noe_n   = 1'b1;
          state_n = ST_ABSENT;
        end
      end
      ST_IDLE: begin
        if (rd_req) begin
          first_n = 1'b0;
          addr_n  = rd_addr;
          launch  = 1'b1;
        end
      end
      ST_LOW: begin
        if (tick) begin
          sk_n    = 1'b1;
          k_n     = k_q + K_W'(1);
          state_n = ST_HIGH;
          if (first_q && (kin == PROBE_K)) begin
            wide_n   = di_s;
            aw_probe = di_s ? AW_LARGE : AW_SMALL;
          end
          if ((kin >= aw_probe + 5) && (kin <= aw_probe + DATA_W + 4))
            rx_shift = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sk_n = 1'b0;
          if (int'(k_q) == aw_now + DATA_W + 4) begin
            cs_n    = 1'b0;
            do_n    = 1'b0;
            wv_n    = 1'b1;
            gap_n   = 1'b0;
            state_n = ST_GAP;
          end else begin
            do_n    = nxt_bit;
            state_n = ST_LOW;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q) state_n = ST_IDLE;
          else       gap_n   = 1'b1;
        end
      end
      ST_ABSENT: begin
        state_n = ST_ABSENT;
      end
      default: state_n = ST_IDLE;
    endcase

    if (launch) begin
      cs_n    = 1'b1;
      sk_n    = 1'b0;
      do_n    = 1'b1;
      k_n     = '0;
      rx_clr  = 1'b1;
      state_n = ST_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_WAKE;
      k_q     <= '0;
      wide_q  <= 1'b0;
      first_q <= 1'b0;
      addr_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      do_q    <= 1'b0;
      wv_q    <= 1'b0;
      noe_q   <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      k_q     <= k_n;
      wide_q  <= wide_n;
      first_q <= first_n;
      addr_q  <= addr_n;
      cs_q    <= cs_n;
      sk_q    <= sk_n;
      do_q    <= do_n;
      wv_q    <= wv_n;
      noe_q   <= noe_n;
      gap_q   <= gap_n;
    end
  end

  assign ee_cs      = cs_q;
  assign ee_sk      = sk_q;
  assign ee_do      = do_q;
  assign word_valid = wv_q;
  assign no_eeprom  = noe_q;
  assign wide_addr  = wide_q;
  assign busy       = (state_q != ST_IDLE) && (state_q != ST_ABSENT);
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int HALF_DIV = 100
) (
  input logic clk,
  input logic rst_n,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do,
  input logic busy,
  input logic word_valid,
  input logic no_eeprom
);
  localparam int GAP_MIN = 2 * HALF_DIV;
  localparam int LW      = $clog2(GAP_MIN + 1) + 1;

  logic [LW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= LW'(GAP_MIN);
    end else begin
      hi_cnt <= ee_sk ? hi_cnt + LW'(1) : '0;
      if (ee_cs)                     lo_cnt <= '0;
      else if (lo_cnt < LW'(GAP_MIN)) lo_cnt <= lo_cnt + LW'(1);
    end
  end

  // R4
  sk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> (hi_cnt == LW'(HALF_DIV)));

  // R5
  do_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_do));

  // R9
  sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (lo_cnt >= LW'(GAP_MIN)));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R11
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> busy);

  // R1
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_eeprom |-> (!ee_cs && !busy && !word_valid));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
  .busy(busy), .word_valid(word_valid), .no_eeprom(no_eeprom)
);

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
  localparam int HALF = 100;

  logic        clk, rst_n, ee_di, ee_cs, ee_sk, ee_do;
  logic        rd_req, busy, word_valid, no_eeprom, wide_addr;
  logic [7:0]  rd_addr;
  logic [15:0] word_data;

  mw_eeprom_reader #(.HALF_DIV(HALF)) u_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .ee_di(ee_di), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_do(ee_do), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
    .word_valid(word_valid), .word_data(word_data), .no_eeprom(no_eeprom),
    .wide_addr(wide_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [7:0] a, input int aw);
    logic [7:0] m;
    m = (aw == 6) ? (a & 8'h3F) : a;
    return {m ^ 8'h3C, ~m};
  endfunction

  // EEPROM model: answers with bench-chosen address width
  logic       idle_lvl = 1'b0;
  int         model_aw = 6;
  logic       model_out = 1'b1;
  int         r = 0;
  int         proto_err = 0;
  logic [7:0] rx_addr = 8'h00;
  logic [15:0] tmp_w;
  assign ee_di = ee_cs ? model_out : idle_lvl;

  always @(posedge ee_cs) begin
    r = 0; model_out = 1'b1; rx_addr = 8'h00;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    r++;
    if ((r == 1 || r == 2) && ee_do !== 1'b1) proto_err++;
    if (r == 3 && ee_do !== 1'b0) proto_err++;
    if (r >= 4 && r <= 3 + model_aw) rx_addr = {rx_addr[6:0], ee_do};
    if (r == 3 + model_aw) model_out = 1'b0;
    else if (r >= 4 + model_aw && r <= 19 + model_aw) begin
      tmp_w = mem_word(rx_addr, model_aw);
      model_out = tmp_w[19 + model_aw - r];
    end else if (r > 19 + model_aw) model_out = 1'b1;
  end

  // protocol monitors
  int hi_len = 0, lo_len = 0, gap_len = 0;
  int sk_err = 0, do_err = 0, gap_err = 0, cs_rises = 0, wv_cnt = 0;
  logic prev_sk = 1'b0, prev_do = 1'b0, prev_cs = 1'b0;
  always @(negedge clk) begin
    if (ee_sk) begin
      hi_len++;
      if (lo_len != 0 && lo_len != HALF) sk_err++;
      lo_len = 0;
    end else begin
      if (hi_len != 0 && hi_len != HALF) sk_err++;
      hi_len = 0;
      if (ee_cs) lo_len++; else lo_len = 0;
    end
    if (ee_sk && prev_sk && ee_do != prev_do) do_err++;
    if (ee_cs && !prev_cs) begin
      cs_rises++;
      if (gap_len < 2 * HALF) gap_err++;
    end
    gap_len = ee_cs ? 0 : gap_len + 1;
    prev_sk = ee_sk; prev_do = ee_do; prev_cs = ee_cs;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && word_valid) begin
    wv_cnt++;
    if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", 32'(word_data), 32'h0);
    else begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(word_data == e, t, 32'(word_data), 32'(e));
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    wait_idle();
    exp_q.push_back(mem_word(a, model_aw));
    tag_q.push_back(tag);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'h1);
  endtask

  task automatic apply_reset(input logic lvl);
    rst_n = 1'b0; idle_lvl = lvl;
    repeat (5) @(negedge clk);
    chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R9 reset state", {30'h0, ee_cs, ee_sk}, 32'h0);
    rst_n = 1'b1;
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = 8'h00;

    // absent device (R1)
    model_aw = 6;
    apply_reset(1'b0);
    repeat (10) @(negedge clk);
    chk(no_eeprom == 1'b1, "R1 no_eeprom", 32'(no_eeprom), 32'h1);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 32'h0);
    rd_req = 1'b1; rd_addr = 8'h12;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2000) @(negedge clk);
    chk(cs_rises == 0, "R1 chip select", 32'(cs_rises), 32'h0);
    chk(wv_cnt == 0, "R1 word_valid", 32'(wv_cnt), 32'h0);

    // small device: probe coincides with the dummy bit (R2, R6, R7)
    model_aw = 6;
    exp_q.push_back(mem_word(8'h00, 6)); tag_q.push_back("R2 auto word 0");
    apply_reset(1'b1);
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R2 busy during start-up read", 32'(busy), 32'h1);
    wait_idle();
    chk(wide_addr == 1'b0, "R6 small width", 32'(wide_addr), 32'h0);
    chk(no_eeprom == 1'b0, "R1 present", 32'(no_eeprom), 32'h0);
    do_read(8'h05, "R3 small read");
    repeat (300) @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'h22;   // R10: raised while busy
    @(negedge clk);
    rd_req = 1'b0;
    do_read(8'h3F, "R8 small read");
    do_read(8'hC5, "R7 upper bits ignored");
    wait_idle();
    chk(exp_q.size() == 0, "R10 queue drained", 32'(exp_q.size()), 32'h0);

    // large device (R6)
    model_aw = 8;
    exp_q.push_back(mem_word(8'h00, 8)); tag_q.push_back("R6 auto word 0 large");
    apply_reset(1'b1);
    wait_idle();
    chk(wide_addr == 1'b1, "R6 large width", 32'(wide_addr), 32'h1);
    do_read(8'hFF, "R3 large read");
    do_read(8'hA5, "R8 large read");
    do_read(8'h80, "R6 width kept");
    wait_idle();
    chk(exp_q.size() == 0, "R8 queue drained", 32'(exp_q.size()), 32'h0);

    chk(proto_err == 0, "R3 frame bits", 32'(proto_err), 32'h0);
    chk(sk_err == 0, "R4 clock phases", 32'(sk_err), 32'h0);
    chk(do_err == 0, "R5 data-out stable", 32'(do_err), 32'h0);
    chk(gap_err == 0, "R9 select gap", 32'(gap_err), 32'h0);
    finish_run();
  end
endmodule